// File: doc/BRIEF.md
# Cache Allocation Policy Controller

This block makes the policy decision for each access the second-level cache receives from the instruction side or the data side. It does not hold tags or data. For each access it reports five things: whether a hit may be served from the cache, whether a miss may allocate a new line, whether the access bypasses the cache, whether a write must also go to the system bus, and which coherence state a written or filled line takes. The decision appears one cycle after the access is presented.

A small control register holds four bits: enable, data-only, instruction-only and write-through. A write to this register can also carry a global-invalidate command. When an invalidate is accepted, a sequencer steps an index through every set, one set per cycle, so that the tag store can clear its valid bits. Two control sequences are illegal: turning on write-through while the cache is enabled, and invalidating while the cache is enabled or during a sweep. The block rejects such a write as a whole and pulses an error flag.

Top module: `cache_alloc_policy`

## Requirements
- R1: After reset all control bits are clear, no decision is valid, no sweep is running and the error flag is low.
- R2: A decision appears on the outputs exactly one cycle after the access is presented. While the cache is disabled every access bypasses, never allocates, takes line state 2'b00 (no change), and writes to the bus exactly when the access is a write.
- R3: A control write takes effect from the next access. An access presented in the same cycle as the write is decided under the old settings.
- R4: With the cache enabled, a hit is served from the cache (hit_use=1, bypass=0, alloc=0). A read hit leaves the line state at 2'b00.
- R5: With the cache enabled and no mode restriction, a miss allocates. A read fill takes state 2'b01 (exclusive).
- R6: In data-only mode, instruction-side hits use the cache, while instruction-side misses bypass it without allocating. Data-side misses still allocate.
- R7: In instruction-only mode, data-side hits use the cache, including writes. Data-side misses bypass without allocating.
- R8: With both modes set, no miss allocates on either side, while a write hit still updates the cache.
- R9: In write-back mode a cached write does not go to the bus and the line takes state 2'b10 (modified). In write-through mode every write goes to the bus and a cached write takes state 2'b01, never 2'b10.
- R10: A control write that sets write-through while the cache is enabled and write-through is clear pulses err_o for one cycle and changes no control bit.
- R11: A control write that requests invalidate while the cache is enabled, or that sets enable at the same time, pulses err_o and starts no sweep.
- R12: An accepted invalidate raises inval_busy_o for exactly SETS cycles, with inval_idx_o counting 0 to SETS-1. During the sweep, a control write that sets enable or invalidate is rejected with err_o, and accesses bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (hard or power-on) |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_enable_i | input | 1 | New enable bit |
| cfg_data_only_i | input | 1 | New data-only bit |
| cfg_instr_only_i | input | 1 | New instruction-only bit |
| cfg_wthru_i | input | 1 | New write-through bit |
| cfg_inval_i | input | 1 | Global invalidate command carried with the write |
| txn_valid_i | input | 1 | Access presented this cycle |
| txn_instr_i | input | 1 | 1 = instruction side, 0 = data side |
| txn_write_i | input | 1 | 1 = write, 0 = read |
| txn_hit_i | input | 1 | Tag lookup hit |
| dec_valid_o | output | 1 | Decision valid |
| dec_hit_use_o | output | 1 | Hit served from cache |
| dec_alloc_o | output | 1 | Miss allocates a line |
| dec_bypass_o | output | 1 | Access bypasses the cache |
| dec_bus_wr_o | output | 1 | Write also goes to the system bus |
| dec_state_o | output | 2 | Line state: 00 keep, 01 exclusive, 10 modified |
| err_o | output | 1 | One-cycle pulse on a rejected control write |
| inval_busy_o | output | 1 | Invalidate sweep running |
| inval_idx_o | output | $clog2(SETS) | Set to clear during the sweep |

## Verification
Some rules hold on every cycle, and the assertions check these:
- a decision follows each access one cycle later;
- a disabled cache always bypasses;
- allocate, bypass and hit-use never coexist;
- locked mode never allocates;
- write-through never yields the modified state and always writes the bus;
- a rejected write leaves the control bits unchanged;
- a sweep steps its index one set per cycle with the cache off.

Other behaviour shows only in the bench's scenarios:
- the one-access boundary at which a new setting applies;
- the side-specific effect of data-only and instruction-only mode;
- the exact sweep length;
- the rejection of an enable or invalidate issued during a sweep.

// File: rtl/cache_policy_pkg.sv
package cache_policy_pkg;

  typedef enum logic [1:0] {
    LS_KEEP = 2'b00,
    LS_EXCL = 2'b01,
    LS_MOD  = 2'b10
  } line_state_e;

  typedef struct packed {
    logic enable;
    logic data_only;
    logic instr_only;
    logic wthru;
  } pol_cfg_t;

  typedef struct packed {
    logic        hit_use;
    logic        alloc;
    logic        bypass;
    logic        bus_wr;
    line_state_e state;
  } pol_dec_t;

endpackage

// File: rtl/cpc_cfg_reg.sv
module cpc_cfg_reg
  import cache_policy_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  logic     enable_i,
  input  logic     data_only_i,
  input  logic     instr_only_i,
  input  logic     wthru_i,
  input  logic     inval_i,
  input  logic     busy_i,
  output pol_cfg_t cfg_o,
  output logic     inval_start_o,
  output logic     err_o
);

  pol_cfg_t cfg_q;
  logic     err_q;
  logic     bad_wt, bad_inv, bad_busy, bad;

  // write-through may only be turned on while disabled
  assign bad_wt   = wthru_i & ~cfg_q.wthru & cfg_q.enable;
  assign bad_inv  = inval_i & (cfg_q.enable | enable_i);
  assign bad_busy = busy_i & (enable_i | inval_i);
  assign bad      = bad_wt | bad_inv | bad_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= we_i & bad;
      if (we_i && !bad) begin
        cfg_q.enable     <= enable_i;
        cfg_q.data_only  <= data_only_i;
        cfg_q.instr_only <= instr_only_i;
        cfg_q.wthru      <= wthru_i;
      end
    end
  end

  assign inval_start_o = we_i & ~bad & inval_i;
  assign cfg_o         = cfg_q;
  assign err_o         = err_q;

endmodule

// File: rtl/cpc_inval_seq.sv
module cpc_inval_seq #(
  parameter int unsigned SETS  = 64,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;

endmodule

// File: rtl/cpc_decide.sv
module cpc_decide
  import cache_policy_pkg::*;
(
  input  pol_cfg_t cfg_i,
  input  logic     instr_i,
  input  logic     write_i,
  input  logic     hit_i,
  output pol_dec_t dec_o
);

  logic        miss_blocked;
  line_state_e wr_state;

  assign miss_blocked = instr_i ? cfg_i.data_only : cfg_i.instr_only;
  assign wr_state     = cfg_i.wthru ? LS_EXCL : LS_MOD;

  always_comb begin
    dec_o       = '0;
    dec_o.state = LS_KEEP;
    if (!cfg_i.enable) begin
      dec_o.bypass = 1'b1;
      dec_o.bus_wr = write_i;
    end else if (hit_i) begin
      dec_o.hit_use = 1'b1;
      dec_o.bus_wr  = write_i & cfg_i.wthru;
      dec_o.state   = write_i ? wr_state : LS_KEEP;
    end else if (miss_blocked) begin
      // treated as cache-inhibited
      dec_o.bypass = 1'b1;
      dec_o.bus_wr = write_i;
    end else begin
      dec_o.alloc  = 1'b1;
      dec_o.bus_wr = write_i & cfg_i.wthru;
      dec_o.state  = write_i ? wr_state : LS_EXCL;
    end
  end

endmodule

// File: rtl/cache_alloc_policy.sv
module cache_alloc_policy
  import cache_policy_pkg::*;
#(
  parameter int unsigned SETS  = 64,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_enable_i,
  input  logic             cfg_data_only_i,
  input  logic             cfg_instr_only_i,
  input  logic             cfg_wthru_i,
  input  logic             cfg_inval_i,
  input  logic             txn_valid_i,
  input  logic             txn_instr_i,
  input  logic             txn_write_i,
  input  logic             txn_hit_i,
  output logic             dec_valid_o,
  output logic             dec_hit_use_o,
  output logic             dec_alloc_o,
  output logic             dec_bypass_o,
  output logic             dec_bus_wr_o,
  output logic [1:0]       dec_state_o,
  output logic             err_o,
  output logic             inval_busy_o,
  output logic [IDX_W-1:0] inval_idx_o
);

  pol_cfg_t cfg_q;
  pol_dec_t dec_c, dec_q;
  logic     dec_valid_q;
  logic     inval_start;
  logic     busy;

  cpc_cfg_reg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .enable_i     (cfg_enable_i),
    .data_only_i  (cfg_data_only_i),
    .instr_only_i (cfg_instr_only_i),
    .wthru_i      (cfg_wthru_i),
    .inval_i      (cfg_inval_i),
    .busy_i       (busy),
    .cfg_o        (cfg_q),
    .inval_start_o(inval_start),
    .err_o        (err_o)
  );

  cpc_inval_seq #(.SETS(SETS)) u_inval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(inval_start),
    .busy_o (busy),
    .idx_o  (inval_idx_o)
  );

  cpc_decide u_dec (
    .cfg_i  (cfg_q),
    .instr_i(txn_instr_i),
    .write_i(txn_write_i),
    .hit_i  (txn_hit_i),
    .dec_o  (dec_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_q <= 1'b0;
      dec_q       <= '0;
    end else begin
      dec_valid_q <= txn_valid_i;
      dec_q       <= txn_valid_i ? dec_c : '0;
    end
  end

  assign dec_valid_o   = dec_valid_q;
  assign dec_hit_use_o = dec_q.hit_use;
  assign dec_alloc_o   = dec_q.alloc;
  assign dec_bypass_o  = dec_q.bypass;
  assign dec_bus_wr_o  = dec_q.bus_wr;
  assign dec_state_o   = dec_q.state;
  assign inval_busy_o  = busy;

endmodule

// File: rtl/cpc_chk.sv
module cpc_chk
  import cache_policy_pkg::*;
#(
  parameter int unsigned SETS  = 64,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             txn_valid_i,
  input logic             txn_write_i,
  input logic             dec_valid_o,
  input logic             dec_hit_use_o,
  input logic             dec_alloc_o,
  input logic             dec_bypass_o,
  input logic             dec_bus_wr_o,
  input logic [1:0]       dec_state_o,
  input logic             err_o,
  input logic             inval_busy_o,
  input logic [IDX_W-1:0] inval_idx_o,
  input pol_cfg_t         cfg_q
);

  // R2
  dec_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_i |=> dec_valid_o);

  // R2
  no_spurious_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txn_valid_i |=> !dec_valid_o);

  // R2
  disabled_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && !cfg_q.enable) |=>
      (dec_bypass_o && !dec_alloc_o && dec_bus_wr_o == $past(txn_write_i)));

  // R4
  excl_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $countones({dec_hit_use_o, dec_alloc_o, dec_bypass_o}) == 1);

  // R8
  locked_no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && cfg_q.data_only && cfg_q.instr_only) |=> !dec_alloc_o);

  // R9
  wthru_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && txn_write_i && cfg_q.wthru) |=>
      (dec_bus_wr_o && dec_state_o != LS_MOD));

  // R10
  err_keeps_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(cfg_q));

  // R11
  sweep_not_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inval_busy_o) |-> !err_o);

  // R12
  sweep_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_busy_o |-> !cfg_q.enable);

  // R12
  sweep_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_busy_o && $past(inval_busy_o)) |->
      inval_idx_o == $past(inval_idx_o) + 1'b1);

  // R12
  sweep_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inval_busy_o) |-> inval_idx_o == '0);

endmodule

bind cache_alloc_policy cpc_chk #(.SETS(SETS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .txn_valid_i  (txn_valid_i),
  .txn_write_i  (txn_write_i),
  .dec_valid_o  (dec_valid_o),
  .dec_hit_use_o(dec_hit_use_o),
  .dec_alloc_o  (dec_alloc_o),
  .dec_bypass_o (dec_bypass_o),
  .dec_bus_wr_o (dec_bus_wr_o),
  .dec_state_o  (dec_state_o),
  .err_o        (err_o),
  .inval_busy_o (inval_busy_o),
  .inval_idx_o  (inval_idx_o),
  .cfg_q        (cfg_q)
);

// File: tb/sim_cache_alloc_policy.sv
`timescale 1ns/1ps
module sim_cache_alloc_policy;

  localparam int SETS  = 8;
  localparam int IDX_W = $clog2(SETS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, cfg_do = 0, cfg_io = 0, cfg_wt = 0, cfg_inv = 0;
  logic txn_valid = 0, txn_instr = 0, txn_write = 0, txn_hit = 0;
  logic dec_valid, dec_hit_use, dec_alloc, dec_bypass, dec_bus_wr, err, busy;
  logic [1:0] dec_state;
  logic [IDX_W-1:0] idx;

  always #2.5 clk = ~clk;

  cache_alloc_policy #(.SETS(SETS)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_enable_i(cfg_en), .cfg_data_only_i(cfg_do),
    .cfg_instr_only_i(cfg_io), .cfg_wthru_i(cfg_wt), .cfg_inval_i(cfg_inv),
    .txn_valid_i(txn_valid), .txn_instr_i(txn_instr), .txn_write_i(txn_write),
    .txn_hit_i(txn_hit),
    .dec_valid_o(dec_valid), .dec_hit_use_o(dec_hit_use), .dec_alloc_o(dec_alloc),
    .dec_bypass_o(dec_bypass), .dec_bus_wr_o(dec_bus_wr), .dec_state_o(dec_state),
    .err_o(err), .inval_busy_o(busy), .inval_idx_o(idx)
  );

  typedef struct {
    bit       hu, al, bp, bw;
    bit [1:0] st;
    string    tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0, n_fail = 0;

  // bench model of the control bits
  bit m_en = 0, m_do = 0, m_io = 0, m_wt = 0;
  int busy_cnt = 0;
  bit start_req = 0;

  always @(posedge clk) begin
    if (start_req) begin
      busy_cnt  = SETS;
      start_req = 0;
    end else if (busy_cnt > 0) begin
      busy_cnt = busy_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic exp_t predict(input bit ti, tw, th, input string tag);
    exp_t e;
    bit   blocked;
    e = '{0, 0, 0, 0, 2'b00, tag};
    blocked = ti ? m_do : m_io;
    if (!m_en) begin
      e.bp = 1; e.bw = tw;
    end else if (th) begin
      e.hu = 1; e.bw = tw & m_wt; e.st = tw ? (m_wt ? 2'b01 : 2'b10) : 2'b00;
    end else if (blocked) begin
      e.bp = 1; e.bw = tw;
    end else begin
      e.al = 1; e.bw = tw & m_wt; e.st = tw ? (m_wt ? 2'b01 : 2'b10) : 2'b01;
    end
    return e;
  endfunction

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic drive(input bit cw, en, d, io, wt, inv,
                       input bit tv, ti, tw, th, input string tag);
    bit bad;
    @(negedge clk);
    bad = (wt & !m_wt & m_en) | (inv & (m_en | en)) | ((busy_cnt > 0) & (en | inv));
    if (tv) exp_q.push_back(predict(ti, tw, th, tag));
    cfg_we = cw; cfg_en = en; cfg_do = d; cfg_io = io; cfg_wt = wt; cfg_inv = inv;
    txn_valid = tv; txn_instr = ti; txn_write = tw; txn_hit = th;
    if (cw && !bad) begin
      m_en = en; m_do = d; m_io = io; m_wt = wt;
      if (inv) start_req = 1;
    end
    @(posedge clk);
    #1;
    if (cw) chk(err == (cw & bad), tag, "err_o", err, cw & bad);
    cfg_we = 0; cfg_inv = 0; txn_valid = 0;
  endtask

  task automatic cfg(input bit en, d, io, wt, inv, input string tag);
    drive(1, en, d, io, wt, inv, 0, 0, 0, 0, tag);
  endtask

  task automatic txn(input bit ti, tw, th, input string tag);
    drive(0, 0, 0, 0, 0, 0, 1, ti, tw, th, tag);
  endtask

  // monitor: compare decisions in order
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dec_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2", "unexpected decision", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({dec_hit_use, dec_alloc, dec_bypass, dec_bus_wr, dec_state} ==
              {e.hu, e.al, e.bp, e.bw, e.st}, e.tag, "{hit,alloc,byp,bus,state}",
              int'({dec_hit_use, dec_alloc, dec_bypass, dec_bus_wr, dec_state}),
              int'({e.hu, e.al, e.bp, e.bw, e.st}));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R1: reset state
    chk({dec_valid, err, busy, dec_alloc, dec_bypass, dec_state} == '0, "R1",
        "outputs after reset", int'({dec_valid, err, busy}), 0);
    chk(idx == '0, "R1", "inval_idx_o", idx, 0);

    // R2: disabled, every pattern bypasses
    txn(0, 0, 1, "R2");
    txn(0, 1, 0, "R2");
    txn(1, 0, 0, "R2");
    txn(1, 1, 1, "R2");

    // R3: enable with an access in the same cycle -> old settings
    drive(1, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
    txn(0, 0, 0, "R3");

    // R4 / R5: write-back hits and misses
    txn(0, 0, 1, "R4");
    txn(1, 0, 1, "R4");
    txn(1, 0, 0, "R5");
    txn(0, 1, 0, "R5");
    txn(0, 1, 1, "R9");

    // R10: write-through turned on while enabled is rejected
    cfg(1, 0, 0, 1, 0, "R10");
    txn(0, 1, 1, "R10");
    chk(!err, "R10", "err_o single pulse", err, 0);

    // R11: invalidate while enabled is rejected
    cfg(1, 0, 0, 0, 1, "R11");
    chk(!busy, "R11", "inval_busy_o", busy, 0);
    txn(0, 0, 0, "R11");
    cfg(0, 0, 0, 0, 0, "R11");
    cfg(1, 0, 0, 0, 1, "R11");
    chk(!busy, "R11", "inval_busy_o with enable", busy, 0);

    // R9: write-through set while disabled, then enabled
    cfg(0, 0, 0, 1, 0, "R9");
    cfg(1, 0, 0, 1, 0, "R9");
    txn(0, 1, 1, "R9");
    txn(0, 1, 0, "R9");
    txn(1, 0, 0, "R9");
    cfg(1, 0, 0, 0, 0, "R9");
    txn(0, 1, 1, "R9");

    // R6: data-only
    cfg(1, 1, 0, 0, 0, "R6");
    txn(1, 0, 1, "R6");
    txn(1, 0, 0, "R6");
    txn(0, 0, 0, "R6");

    // R7: instruction-only
    cfg(1, 0, 1, 0, 0, "R7");
    txn(0, 1, 1, "R7");
    txn(0, 1, 0, "R7");
    txn(0, 0, 0, "R7");
    txn(1, 0, 0, "R7");

    // R8: locked
    cfg(1, 1, 1, 0, 0, "R8");
    txn(0, 0, 0, "R8");
    txn(1, 0, 0, "R8");
    txn(0, 1, 0, "R8");
    txn(0, 1, 1, "R8");

    // R12: full sweep with index sequence
    cfg(0, 0, 0, 0, 0, "R12");
    cfg(0, 0, 0, 0, 1, "R12");
    for (int k = 0; k < SETS; k++) begin
      chk(busy && idx == k[IDX_W-1:0], "R12", "sweep index", idx, k);
      @(posedge clk); #1;
    end
    chk(!busy, "R12", "busy after SETS cycles", busy, 0);

    // R12: enable during a sweep is rejected, access bypasses
    cfg(0, 0, 0, 0, 1, "R12");
    drive(1, 1, 0, 0, 0, 0, 1, 0, 0, 1, "R12");
    txn(0, 1, 1, "R12");
    repeat (SETS) @(posedge clk);
    #1 chk(!busy, "R12", "second sweep ends", busy, 0);
    txn(0, 0, 1, "R12");

    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R2", "decisions missing", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule